// File: doc/BRIEF.md
# Infrared Receive Byte Buffer with Interrupt Flags

This block sits behind an infrared pulse sampler and holds the run-length code bytes that the sampler produces. Each byte goes into a first-in first-out store whose depth is a parameter. Software drains the store through a small register port. Software reads the data register once for every byte it wants to take out.

Three sticky flags tell software that something needs attention:

- The buffer has overflowed.
- The sampler has reported the end of a packet.
- The fill level has gone above a programmable trigger level.

Each flag has its own enable bit. The enabled flags are ORed into one interrupt line. The status word also carries the live fill count, so a handler can find out how many bytes to read with a single access.

The register port has a read strobe, a write strobe and a two-bit word address:

| Address | Register |
|---------|----------|
| 0 | Data |
| 1 | Interrupt enable and trigger level |
| 2 | Status |
| 3 | Reads as zero |

Top module: `ir_rx_buffer`

## Requirements
- R1: A read strobe at address 0 returns the oldest stored byte in bits [7:0], with all other bits zero. On that clock edge the byte is removed, so bytes come out in the order they were pushed.
- R2: A read at address 2 shows the number of stored bytes in a field that starts at bit 8 and is wide enough to hold DEPTH.
- R3: Status bit 4 (data available) is set at any clock edge where the fill count before that edge is greater than the trigger level. The trigger level is enable-register bits starting at bit 8, $clog2(DEPTH) bits wide. Once set, the bit stays set until it is cleared.
- R4: A push while the buffer holds DEPTH bytes is dropped, and status bit 0 (overflow) is set. The one exception is a push in the same cycle as a pop: that push is accepted. The fill count never exceeds DEPTH.
- R5: A packet-end pulse from the sampler sets status bit 1 at the next clock edge.
- R6: Writing to address 2 clears each of status bits 0, 1 and 4 whose written bit is one. Writing 0xFF clears all three flags. If a flag is set and cleared in the same cycle, the set wins.
- R7: Address 1 holds the enables for overflow, packet end and data available at bits 0, 1 and 4. Reading it returns what was written. The interrupt output is high exactly when at least one status flag is high together with its enable.
- R8: A read of address 0 while the buffer is empty returns zero and leaves the fill count unchanged.
- R9: After reset the buffer is empty, all flags and enables are zero, the trigger level is zero, and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Sampler offers a code byte this cycle |
| push_data | input | DW | Code byte from the sampler |
| pkt_end | input | 1 | Single-cycle end-of-packet pulse from the sampler |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the buffer at address 0) |
| reg_addr | input | 2 | Word address: 0 data, 1 enable, 2 status |
| reg_wdata | input | RW | Write data |
| reg_rdata | output | RW | Read data for the addressed register (combinational) |
| irq | output | 1 | Combined interrupt request |

## Verification
The buffer is exercised with four kinds of traffic:

- A burst that fills it to the brim and then keeps pushing. This separates dropped bytes from accepted ones and shows the overflow flag setting.
- A push together with a pop while the buffer is full. This shows whether the freed slot is reused.
- Reads on an empty buffer. These show whether the pointers are left untouched.
- A long stretch of mixed pushes, pops, packet-end pulses, clears and enable changes, with the trigger level moved around.

The mixed stretch is where the data-available threshold gets tested. It is only exercised on both sides of the comparison when the count crosses the level in both directions. It also shows whether a clear loses to a condition that is still true.

// File: rtl/ir_rx_buffer.sv
module ir_rx_buffer #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int RW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pkt_end,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp, trig;
  logic [CW-1:0] cnt;
  logic          ovf, pkt, av;
  logic [2:0]    ien;

  wire sel_dat = reg_addr == 2'd0;
  wire sel_en  = reg_addr == 2'd1;
  wire sel_sta = reg_addr == 2'd2;
  wire pop     = reg_rd & sel_dat & (cnt != '0);
  wire acc     = push_valid & ((cnt != FULL) | pop);
  wire wr_sta  = reg_wr & sel_sta;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[RW-1:8+AW], reg_wdata[7:5], reg_wdata[3:2]};

  always_ff @(posedge clk) begin
    if (acc) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
      pkt  <= 1'b0;
      av   <= 1'b0;
      ien  <= '0;
      trig <= '0;
    end else begin
      if (acc) wp <= wp + 1'b1;
      if (pop) rp <= rp + 1'b1;
      cnt <= cnt + CW'(acc) - CW'(pop);
      ovf <= (ovf & ~(wr_sta & reg_wdata[0])) | (push_valid & ~acc);
      pkt <= (pkt & ~(wr_sta & reg_wdata[1])) | pkt_end;
      av  <= (av  & ~(wr_sta & reg_wdata[4])) | (cnt > CW'(trig));
      if (reg_wr & sel_en) begin
        ien  <= {reg_wdata[4], reg_wdata[1], reg_wdata[0]};
        trig <= reg_wdata[8 +: AW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: if (cnt != '0) reg_rdata[DW-1:0] = mem[rp];
      2'd1: begin
        reg_rdata[0]      = ien[0];
        reg_rdata[1]      = ien[1];
        reg_rdata[4]      = ien[2];
        reg_rdata[8 +: AW] = trig;
      end
      2'd2: begin
        reg_rdata[0]      = ovf;
        reg_rdata[1]      = pkt;
        reg_rdata[4]      = av;
        reg_rdata[8 +: CW] = cnt;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign irq = (ovf & ien[0]) | (pkt & ien[1]) | (av & ien[2]);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL);

  // R4
  drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && cnt == FULL && !(reg_rd && reg_addr == 2'd0)) |=> ovf);

  // R5
  pkt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) pkt_end |=> pkt);

  // R8
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && cnt == '0 && !push_valid) |=> cnt == '0);

  // R1
  pop_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 2'd0 && cnt != '0 && !push_valid) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: tb/ir_rx_buffer_bench.sv
module ir_rx_buffer_bench;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic push_valid = 0, pkt_end = 0, reg_wr = 0, reg_rd = 0;
  logic [7:0] push_data = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic irq;

  always #4 clk = ~clk;

  ir_rx_buffer #(.DEPTH(DEPTH)) u_ir_rx_buffer (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
    .pkt_end(pkt_end), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  bit m_ovf, m_pkt, m_av;
  bit [2:0] m_en;
  int m_trig;
  int n;
  bit popm, accm, wr2;
  bit done = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_ovf = 0; m_pkt = 0; m_av = 0; m_en = 0; m_trig = 0;
    end else begin
      n = q.size();
      popm = reg_rd && reg_addr == 0 && n > 0;
      accm = push_valid && (n < DEPTH || popm);
      wr2 = reg_wr && reg_addr == 2;
      m_ovf = (m_ovf && !(wr2 && reg_wdata[0])) || (push_valid && !accm);
      m_pkt = (m_pkt && !(wr2 && reg_wdata[1])) || pkt_end;
      m_av  = (m_av  && !(wr2 && reg_wdata[4])) || (n > m_trig);
      if (reg_wr && reg_addr == 1) begin
        m_en = {reg_wdata[4], reg_wdata[1], reg_wdata[0]};
        m_trig = int'(reg_wdata[8 +: AW]);
      end
      if (popm) void'(q.pop_front());
      if (accm) q.push_back(push_data);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 irq", irq, (m_ovf & m_en[0]) | (m_pkt & m_en[1]) | (m_av & m_en[2]));
      case (reg_addr)
        2'd0: if (q.size() > 0) chk("R1 data", reg_rdata, q[0]);
              else chk("R8 empty data", reg_rdata, 0);
        2'd1: chk("R7 enable readback", reg_rdata,
                  (m_trig << 8) | (m_en[2] << 4) | (m_en[1] << 1) | m_en[0]);
        2'd2: begin
          chk("R2 count", reg_rdata[31:8], q.size());
          chk("R4 ovf", reg_rdata[0], m_ovf);
          chk("R5 pkt", reg_rdata[1], m_pkt);
          chk("R3 avail", reg_rdata[4], m_av);
          chk("R6 spare bits", {reg_rdata[7:5], reg_rdata[3:2]}, 0);
        end
        default: chk("R7 unused address", reg_rdata, 0);
      endcase
    end
  end

  task automatic cyc(input bit p, input logic [7:0] d, input bit pe, input bit w,
                     input bit r, input logic [1:0] a, input logic [31:0] wd);
    push_valid = p; push_data = d; pkt_end = pe; reg_wr = w; reg_rd = r;
    reg_addr = a; reg_wdata = wd;
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reg_addr = 2;
    repeat (3) @(negedge clk);
    chk("R9 reset status", reg_rdata, 0);
    chk("R9 reset irq", irq, 0);
    reg_addr = 1; #1;
    chk("R9 reset enables", reg_rdata, 0);
    @(posedge clk); #2; rst_n = 1;
    cyc(0, 0, 0, 1, 0, 1, 32'h0000_0713);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 8'(8'h30 + i), 0, 0, 0, 2, 0);
    cyc(1, 8'hA5, 0, 0, 1, 0, 0);
    cyc(1, 8'h5A, 0, 0, 0, 2, 0);
    cyc(0, 0, 1, 0, 0, 2, 0);
    cyc(0, 0, 0, 0, 0, 2, 0);
    for (int i = 0; i < DEPTH + 2; i++) cyc(0, 0, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 2, 0);
    cyc(0, 0, 0, 1, 0, 2, 32'hFF);
    cyc(0, 0, 0, 0, 0, 2, 0);
    @(negedge clk);
    chk("R6 clear all", reg_rdata[7:0], 0);
    for (int i = 0; i < 3000; i++) begin
      automatic logic [31:0] rv = $urandom;
      automatic logic [1:0] a = rv[1:0];
      automatic bit w = rv[4:2] == 0 && a != 0;
      cyc(rv[5] | rv[6], rv[15:8], rv[20:16] == 0, w, rv[7] & ~w, a,
          {16'h0, 4'h0, rv[27:24], 3'h0, rv[28], 2'h0, rv[29], rv[30]});
    end
    cyc(0, 0, 0, 0, 0, 2, 0);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule